// File: doc/BRIEF.md
# TDM Audio Link Frame Receiver

This block sits on the controller side of a time-division-multiplexed serial audio link and turns the codec's serial return stream into parallel slot words. The block is clocked by the link bit clock and captures the serial data on every falling edge. The frame-start marker is generated locally and fed back into the block, which uses its rising edge to align a frame position tracker. Each 256-bit frame opens with a 16-bit tag and is followed by twelve 20-bit data slots.

From the tag the receiver takes a codec-ready flag and one valid flag per slot. It then shifts each slot in, most significant bit first. When a slot is complete, the receiver presents the word on a parallel bus with its slot number and a one-cycle strobe, but only if the codec is ready and that slot is flagged valid. A pulse marks the end of every complete frame. A frame marker that arrives early, or that is missing when the frame runs out, raises a one-cycle framing-error pulse and forces the position tracker to realign.

Top module: `tdm_slot_rx`

## Requirements
- R1: While reset is asserted, and after its release until a frame is decoded, slot_stb, frame_done, frame_err and codec_ready are 0.
- R2: Data is captured on the falling edge of bclk. The bit captured on the first falling edge at which sync is seen high after being seen low is frame bit 0, which is the first tag bit.
- R3: The tag is frame bits 0 to 15, sent MSB first. Tag bit 15 (frame bit 0) is codec-ready. Tag bit 15-k (frame bit k) is the valid flag of slot k, for k = 1 to 12. codec_ready shows the new tag's flag right after frame bit 15 has been captured.
- R4: Slot k (1 to 12) occupies frame bits 16+20(k-1) to 35+20(k-1), sent MSB first. A strobe for slot k appears in the cycle after its last bit is captured, with slot_num = k and slot_data holding the 20 bits.
- R5: A slot raises slot_stb only if the current tag has codec-ready = 1 and that slot's valid flag = 1. Otherwise the slot raises no strobe.
- R6: frame_done pulses for one cycle after frame bit 255 has been captured, in the same cycle as any strobe for slot 12. No other bit raises it.
- R7: If sync rises before frame bit 255 has been reached, frame_err pulses for one cycle after that bit is captured. That bit becomes frame bit 0 of a new frame, which then decodes normally.
- R8: If the bit after frame bit 255 arrives without a sync rise, frame_err pulses once and the receiver stops decoding. The next sync rise starts a frame without an error.
- R9: Before the first sync rise after reset, no strobe, frame_done or frame_err is produced, whatever is on sdi.
- R10: The slot shift register is cleared at every field boundary, so each slot word depends only on its own 20 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Link bit clock; data is captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Locally generated frame marker; its rising edge starts a frame |
| sdi | input | 1 | Serial data from the codec |
| codec_ready | output | 1 | Codec-ready flag from the most recent tag |
| slot_stb | output | 1 | One-cycle strobe for a valid slot word |
| slot_num | output | 4 | Number of the strobed slot, 1 to 12 |
| slot_data | output | 20 | Word of the strobed slot |
| frame_done | output | 1 | One-cycle pulse at the end of a complete frame |
| frame_err | output | 1 | One-cycle pulse on an early or missing frame marker |

## Verification
If the position tracker slips by even one bit, the slot words come out rotated, and the strobes move off their slot boundaries within one slot time (20 bit clocks). A wrong ready flag or valid mask in the tag register shows up as missing or extra strobes in the same frame, and a wrong codec_ready value can be seen at bit 15. The bench compares every output on every bit, across sweeps of valid masks, word patterns and frame lengths. A corrupted shifter, flag register or counter is therefore reported at the first bit it affects.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
  parameter int unsigned DEF_TAG_BITS  = 16;
  parameter int unsigned DEF_SLOT_BITS = 20;
  parameter int unsigned DEF_NUM_SLOTS = 12;
endpackage

// File: rtl/tdmrx_framer.sv
module tdmrx_framer #(
  parameter int unsigned TAG_BITS  = tdmrx_pkg::DEF_TAG_BITS,
  parameter int unsigned SLOT_BITS = tdmrx_pkg::DEF_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = tdmrx_pkg::DEF_NUM_SLOTS,
  localparam int unsigned FLD_W    = $clog2(NUM_SLOTS + 1),
  localparam int unsigned BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             sync,
  output logic             bit_vld,
  output logic [FLD_W-1:0] fld,
  output logic             fld_last,
  output logic             frame_err
);
  logic             sync_q;
  logic             locked_q, locked_n;
  logic [FLD_W-1:0] fld_q, fld_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             err_q, err_n;
  logic             sync_rise, q_last, at_end;

  assign sync_rise = sync & ~sync_q;
  assign q_last    = (fld_q == '0) ? (bit_q == BIT_W'(TAG_BITS - 1))
                                   : (bit_q == BIT_W'(SLOT_BITS - 1));
  assign at_end    = locked_q && (fld_q == FLD_W'(NUM_SLOTS)) && q_last;

  always_comb begin
    locked_n = locked_q;
    fld_n    = fld_q;
    bit_n    = bit_q;
    err_n    = 1'b0;
    if (sync_rise) begin
      locked_n = 1'b1;
      fld_n    = '0;
      bit_n    = '0;
      err_n    = locked_q && !at_end;
    end else if (at_end) begin
      locked_n = 1'b0;
      fld_n    = '0;
      bit_n    = '0;
      err_n    = 1'b1;
    end else if (locked_q) begin
      if (q_last) begin
        fld_n = fld_q + FLD_W'(1);
        bit_n = '0;
      end else begin
        bit_n = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      locked_q <= 1'b0;
      fld_q    <= '0;
      bit_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      sync_q   <= sync;
      locked_q <= locked_n;
      fld_q    <= fld_n;
      bit_q    <= bit_n;
      err_q    <= err_n;
    end
  end

  assign bit_vld   = locked_n;
  assign fld       = fld_n;
  assign fld_last  = (fld_n == '0) ? (bit_n == BIT_W'(TAG_BITS - 1))
                                   : (bit_n == BIT_W'(SLOT_BITS - 1));
  assign frame_err = err_q;

  assert_fld_range_R4: assert property (@(negedge bclk) disable iff (!rst_n)
    fld_q <= FLD_W'(NUM_SLOTS));
  assert_tag_len_R3: assert property (@(negedge bclk) disable iff (!rst_n)
    (fld_q == '0) |-> (bit_q < BIT_W'(TAG_BITS)));
  assert_slot_len_R4: assert property (@(negedge bclk) disable iff (!rst_n)
    (fld_q != '0) |-> (bit_q < BIT_W'(SLOT_BITS)));
  assert_unlock_flags_R8: assert property (@(negedge bclk) disable iff (!rst_n)
    $fell(locked_q) |-> err_q);
endmodule

// File: rtl/tdmrx_deser.sv
module tdmrx_deser #(
  parameter int unsigned TAG_BITS  = tdmrx_pkg::DEF_TAG_BITS,
  parameter int unsigned SLOT_BITS = tdmrx_pkg::DEF_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = tdmrx_pkg::DEF_NUM_SLOTS,
  localparam int unsigned FLD_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 sdi,
  input  logic                 bit_vld,
  input  logic [FLD_W-1:0]     fld,
  input  logic                 fld_last,
  output logic                 codec_ready,
  output logic                 slot_stb,
  output logic [FLD_W-1:0]     slot_num,
  output logic [SLOT_BITS-1:0] slot_data,
  output logic                 frame_done
);
  logic [SLOT_BITS-1:0] shift_q, shift_n, word;
  logic [TAG_BITS-1:0]  tag_q, tag_n;
  logic                 stb_q, stb_n, done_q, done_n;
  logic [FLD_W-1:0]     num_q, num_n;
  logic [SLOT_BITS-1:0] data_q, data_n;
  logic [NUM_SLOTS:0]   vld_vec;
  logic                 out_en;

  assign vld_vec[0] = 1'b0;
  for (genvar k = 1; k <= NUM_SLOTS; k++) begin : g_vld
    assign vld_vec[k] = tag_q[TAG_BITS-1-k];
  end

  assign word = {shift_q[SLOT_BITS-2:0], sdi};

  always_comb begin
    shift_n = shift_q;
    tag_n   = tag_q;
    stb_n   = 1'b0;
    done_n  = 1'b0;
    if (bit_vld) begin
      if (fld_last) begin
        shift_n = '0;
        if (fld == '0) begin
          tag_n = word[TAG_BITS-1:0];
        end else begin
          stb_n  = tag_q[TAG_BITS-1] & vld_vec[fld];
          done_n = (fld == FLD_W'(NUM_SLOTS));
        end
      end else begin
        shift_n = word;
      end
    end
  end

  assign out_en = stb_n;
  assign num_n  = out_en ? fld  : num_q;
  assign data_n = out_en ? word : data_q;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      tag_q   <= '0;
      stb_q   <= 1'b0;
      done_q  <= 1'b0;
      num_q   <= '0;
      data_q  <= '0;
    end else begin
      shift_q <= shift_n;
      tag_q   <= tag_n;
      stb_q   <= stb_n;
      done_q  <= done_n;
      num_q   <= num_n;
      data_q  <= data_n;
    end
  end

  assign codec_ready = tag_q[TAG_BITS-1];
  assign slot_stb    = stb_q;
  assign slot_num    = num_q;
  assign slot_data   = data_q;
  assign frame_done  = done_q;

  assert_stb_needs_ready_R5: assert property (@(negedge bclk) disable iff (!rst_n)
    stb_q |-> codec_ready);
  assert_stb_num_R4: assert property (@(negedge bclk) disable iff (!rst_n)
    stb_q |-> ((num_q != '0) && (num_q <= FLD_W'(NUM_SLOTS))));
  assert_done_pulse_R6: assert property (@(negedge bclk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_stb_pulse_R4: assert property (@(negedge bclk) disable iff (!rst_n)
    stb_q |=> !stb_q);
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx #(
  parameter int unsigned TAG_BITS  = tdmrx_pkg::DEF_TAG_BITS,
  parameter int unsigned SLOT_BITS = tdmrx_pkg::DEF_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = tdmrx_pkg::DEF_NUM_SLOTS,
  localparam int unsigned FLD_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 sync,
  input  logic                 sdi,
  output logic                 codec_ready,
  output logic                 slot_stb,
  output logic [FLD_W-1:0]     slot_num,
  output logic [SLOT_BITS-1:0] slot_data,
  output logic                 frame_done,
  output logic                 frame_err
);
  logic             rst_meta, rst_s;
  logic             bit_vld, fld_last;
  logic [FLD_W-1:0] fld;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  tdmrx_framer #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) u_framer (
    .bclk(bclk), .rst_n(rst_s), .sync(sync),
    .bit_vld(bit_vld), .fld(fld), .fld_last(fld_last), .frame_err(frame_err)
  );

  tdmrx_deser #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) u_deser (
    .bclk(bclk), .rst_n(rst_s), .sdi(sdi),
    .bit_vld(bit_vld), .fld(fld), .fld_last(fld_last),
    .codec_ready(codec_ready), .slot_stb(slot_stb), .slot_num(slot_num),
    .slot_data(slot_data), .frame_done(frame_done)
  );

  assert_err_done_apart_R6: assert property (@(negedge bclk) disable iff (!rst_s)
    !(frame_err && frame_done));
  assert_err_no_stb_R7: assert property (@(negedge bclk) disable iff (!rst_s)
    !(frame_err && slot_stb));
endmodule

// File: tb/tdm_slot_rx_tb.sv
module tdm_slot_rx_tb;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        sdi = 1'b0;
  logic        codec_ready, slot_stb, frame_done, frame_err;
  logic [3:0]  slot_num;
  logic [19:0] slot_data;
  int total = 0;
  int fails = 0;

  always #2 bclk = ~bclk;

  tdm_slot_rx u_dut (
    .bclk(bclk), .rst_n(rst_n), .sync(sync), .sdi(sdi),
    .codec_ready(codec_ready), .slot_stb(slot_stb), .slot_num(slot_num),
    .slot_data(slot_data), .frame_done(frame_done), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic put_bit(input logic s, input logic d);
    @(posedge bclk);
    sync = s;
    sdi  = d;
    @(negedge bclk);
    #1;
  endtask

  function automatic logic [19:0] mkword(input int k, input int seed);
    logic [31:0] t;
    if (seed == 1000) return 20'hFFFFF;
    if (seed == 1001) return (k % 2 == 1) ? 20'hFFFFF : 20'h80001;
    t = (32'(k) * 32'h2F1B + 32'(seed) * 32'h61C3) ^ (32'h5A5A5 >> k) ^ (32'(seed) << (k % 8));
    return t[19:0];
  endfunction

  // R2 R3 R4 R5 R6 R7 R10: drive nbits of a frame and compare every output each bit
  task automatic run_frame(input int nbits, input bit rdy, input logic [11:0] vm,
                           input int seed, input bit err_first);
    logic [15:0] tag;
    logic [19:0] w [1:12];
    tag = '0;
    tag[15] = rdy;
    for (int k = 1; k <= 12; k++) begin
      tag[15-k] = vm[k-1];
      w[k] = vm[k-1] ? mkword(k, seed) : 20'h0;
    end
    for (int p = 0; p < nbits; p++) begin
      logic b;
      int k, o;
      bit exp_stb;
      k = (p - 16) / 20 + 1;
      o = (p - 16) % 20;
      b = (p < 16) ? tag[15-p] : w[k][19-o];
      put_bit(p < 16, b);
      exp_stb = (p >= 16) && (o == 19) && rdy && vm[k-1];
      chk(slot_stb == exp_stb, "R5 slot_stb", int'(slot_stb), int'(exp_stb));
      if (exp_stb) begin
        chk(int'(slot_num) == k, "R4 slot_num", int'(slot_num), k);
        chk(slot_data == w[k], "R4 R10 slot_data", int'(slot_data), int'(w[k]));
      end
      chk(frame_done == (p == 255), "R6 frame_done", int'(frame_done), int'(p == 255));
      chk(frame_err == (p == 0 && err_first), "R7 frame_err", int'(frame_err),
          int'(p == 0 && err_first));
      if (p == 15) chk(codec_ready == rdy, "R3 R2 codec_ready", int'(codec_ready), int'(rdy));
    end
  endtask

  // R8 R9: bits with sync low while not in a frame
  task automatic idle_bits(input int n, input bit err_first, input string req);
    for (int i = 0; i < n; i++) begin
      put_bit(1'b0, logic'(i % 3 != 0));
      chk(slot_stb == 1'b0, req, int'(slot_stb), 0);
      chk(frame_done == 1'b0, req, int'(frame_done), 0);
      chk(frame_err == (i == 0 && err_first), req, int'(frame_err), int'(i == 0 && err_first));
    end
  endtask

  initial begin
    #800000;
    fails++;
    total++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge bclk);
    #1;
    chk(slot_stb == 0 && frame_done == 0 && frame_err == 0 && codec_ready == 0,
        "R1 reset outputs", int'({slot_stb, frame_done, frame_err, codec_ready}), 0);
    @(posedge bclk);
    rst_n = 1'b1;
    repeat (4) @(negedge bclk);
    #1;
    chk(slot_stb == 0 && frame_done == 0 && frame_err == 0 && codec_ready == 0,
        "R1 after release", int'({slot_stb, frame_done, frame_err, codec_ready}), 0);
    // R9 noise before any sync
    idle_bits(40, 1'b0, "R9 pre-lock");
    // R2 R4 R10 patterns
    run_frame(256, 1'b1, 12'hFFF, 1000, 1'b0);
    run_frame(256, 1'b1, 12'hFFF, 1001, 1'b0);
    // R5 walking valid flag
    for (int k = 0; k < 12; k++) run_frame(256, 1'b1, 12'(1 << k), k + 3, 1'b0);
    run_frame(256, 1'b1, 12'hA5C, 77, 1'b0);
    run_frame(256, 1'b1, 12'h3F0, 78, 1'b0);
    run_frame(256, 1'b1, 12'h000, 79, 1'b0);
    // R5 codec not ready
    run_frame(256, 1'b0, 12'hFFF, 80, 1'b0);
    run_frame(256, 1'b1, 12'hFFF, 81, 1'b0);
    // R7 early marker, then resync
    run_frame(150, 1'b1, 12'hFFF, 82, 1'b0);
    run_frame(256, 1'b1, 12'h7E7, 83, 1'b1);
    run_frame(17, 1'b1, 12'hFFF, 84, 1'b0);
    run_frame(256, 1'b1, 12'hFFF, 85, 1'b1);
    // R8 missing marker
    idle_bits(5, 1'b1, "R8 late");
    run_frame(256, 1'b1, 12'hC3C, 86, 1'b0);
    run_frame(256, 1'b1, 12'hFFF, 87, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule